// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general and saved-status register storage of a 32-bit processor core that runs in seven operating modes. A 5-bit mode code from the current status register picks a bank, and the block maps each of the sixteen logical register numbers onto one of 31 physical general registers. Some registers are private to a mode. The fast-interrupt mode has its own copies of the upper seven registers below the program counter. The four other exception modes have their own stack pointer and link register only. User and system mode use one common set. The program counter is a single register that every mode sees.

Reads come from two combinational ports. Writes go through one clocked port. A separate port reads and writes the saved-status register that belongs to the current mode. When the core runs its compressed-instruction state, the high registers R8–R12 can be reached only when the instruction decoder flags one of the special high-register forms. An undefined mode code raises a sticky error flag that blocks every write until reset.

Top module: `banked_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every general register and every saved-status register reads zero and illegal_mode_o is low.
- R2: User mode (10000) and system mode (11111) address the same physical registers R0–R14, so a value written in one mode is read back in the other.
- R3: Fast-interrupt mode (10001) has private copies of R8–R14. A write to R8–R14 in that mode leaves the user copies unchanged. R0–R7 are shared with user mode.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private copies of R13 and R14 only. Their R8–R12 are the user copies.
- R5: R15 is one physical register shared by all seven modes.
- R6: Each of the five exception modes has its own saved-status register. The saved-status port reads and writes the register of the current mode, and a write takes effect at the next clock edge.
- R7: In user and system mode the saved-status port reads zero and writes to it are ignored.
- R8: Both read ports are combinational. When a write targets the register a port is reading, the port shows the old value until the clock edge and the new value after it.
- R9: With compressed_i high and hi_access_i low, reads of R8–R12 return zero on both ports and writes to R8–R12 are ignored. R0–R7 and R13–R15 behave normally. With hi_access_i high, R8–R12 behave normally.
- R10: Any mode code other than the seven listed above raises illegal_mode_o at once. The flag stays high until reset even if the mode code becomes legal again, and while it is high no general or saved-status register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Mode code from the current status register |
| compressed_i | input | 1 | Compressed-instruction state active |
| hi_access_i | input | 1 | Special high-register form permits R8–R12 access in compressed state |
| rd_a_idx_i | input | 4 | Read port A logical register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write logical register number |
| wr_data_i | input | 32 | Write data |
| sr_wr_en_i | input | 1 | Saved-status write enable |
| sr_wr_data_i | input | 32 | Saved-status write data |
| sr_rd_data_o | output | 32 | Saved-status read data for the current mode |
| illegal_mode_o | output | 1 | Undefined mode code seen since reset |

## Verification
The bench writes a register in one mode and reads it in another, both where the two modes share a copy and where they do not. A design that banked the wrong registers would show the fast-interrupt R8 through user mode, or a different supervisor R12. Each exception mode gets its own stack pointer and saved-status value, so two slots that were mixed up would overwrite each other. The bench reads and writes the same register in one cycle to catch a write-through read that shows new data early. It also covers the compressed-state high registers, the saved-status writes in user mode that must be dropped, and an illegal mode code followed by a legal one. A flag that is not sticky would let the later write through.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int NUM_LOGICAL = 16;
  localparam int IDX_W       = $clog2(NUM_LOGICAL);
  localparam int FIQ_FIRST   = 8;                    // first fast-interrupt banked index
  localparam int FIQ_COUNT   = 7;                    // R8..R14
  localparam int PRIV_FIRST  = 13;                   // SP, LR banked in other modes
  localparam int PRIV_COUNT  = 2;
  localparam int NUM_PRIV    = 4;                    // irq, svc, abt, und
  localparam int FIQ_BASE    = NUM_LOGICAL;
  localparam int PRIV_BASE   = FIQ_BASE + FIQ_COUNT;
  localparam int NUM_PHYS    = PRIV_BASE + NUM_PRIV * PRIV_COUNT;  // 31
  localparam int PHYS_W      = $clog2(NUM_PHYS);
  localparam int NUM_SAVED   = 1 + NUM_PRIV;         // fiq + privileged banks
  localparam int SAVED_W     = $clog2(NUM_SAVED);
  localparam int PC_IDX      = NUM_LOGICAL - 1;
  localparam int HI_LO       = 8;                    // compressed state: R8..R12 gated
  localparam int HI_HI       = 12;

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import banked_rf_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o,
  output logic       legal_o
);

  always_comb begin
    legal_o = 1'b1;
    unique case (mode_i)
      MODE_USR, MODE_SYS: bank_o = BK_USR;
      MODE_FIQ:           bank_o = BK_FIQ;
      MODE_IRQ:           bank_o = BK_IRQ;
      MODE_SVC:           bank_o = BK_SVC;
      MODE_ABT:           bank_o = BK_ABT;
      MODE_UND:           bank_o = BK_UND;
      default: begin
        bank_o  = BK_USR;
        legal_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
  import banked_rf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              compressed_i,
  input  logic              hi_access_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              ok_o
);

  logic [PHYS_W-1:0] priv_base;
  logic              is_hi;

  // private SP/LR pair per privileged bank
  always_comb begin
    unique case (bank_i)
      BK_IRQ:  priv_base = PHYS_W'(PRIV_BASE + 0 * PRIV_COUNT);
      BK_SVC:  priv_base = PHYS_W'(PRIV_BASE + 1 * PRIV_COUNT);
      BK_ABT:  priv_base = PHYS_W'(PRIV_BASE + 2 * PRIV_COUNT);
      default: priv_base = PHYS_W'(PRIV_BASE + 3 * PRIV_COUNT);
    endcase
  end

  always_comb begin
    phys_o = PHYS_W'(idx_i);
    if (idx_i == IDX_W'(PC_IDX)) begin
      phys_o = PHYS_W'(PC_IDX);
    end else if (bank_i == BK_FIQ) begin
      if (idx_i >= IDX_W'(FIQ_FIRST))
        phys_o = PHYS_W'(FIQ_BASE) + PHYS_W'(idx_i - IDX_W'(FIQ_FIRST));
    end else if (bank_i != BK_USR) begin
      if (idx_i >= IDX_W'(PRIV_FIRST))
        phys_o = priv_base + PHYS_W'(idx_i - IDX_W'(PRIV_FIRST));
    end
  end

  assign is_hi = (idx_i >= IDX_W'(HI_LO)) && (idx_i <= IDX_W'(HI_HI));
  assign ok_o  = !(compressed_i && !hi_access_i && is_hi);

endmodule

// File: rtl/brf_saved_bank.sv
module brf_saved_bank
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             bank_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0]  saved_q [NUM_SAVED];
  logic [SAVED_W-1:0] slot;
  logic               has_slot;

  assign has_slot = (bank_i != BK_USR);
  assign slot     = has_slot ? SAVED_W'(bank_i - BK_FIQ) : '0;

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        saved_q[s] <= '0;
      else if (wr_en_i && has_slot && (slot == SAVED_W'(s)))
        saved_q[s] <= wr_data_i;
    end
  end

  assign rd_data_o = has_slot ? saved_q[slot] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              compressed_i,
  input  logic              hi_access_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sr_wr_en_i,
  input  logic [DATA_W-1:0] sr_wr_data_i,
  output logic [DATA_W-1:0] sr_rd_data_o,
  output logic              illegal_mode_o
);

  localparam int NUM_PORTS = 3;  // read A, read B, write
  localparam int PORT_WR   = 2;

  bank_e             bank;
  logic              mode_legal;
  logic              illegal_q;
  logic              wr_allow;
  logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
  logic [PHYS_W-1:0] port_phys [NUM_PORTS];
  logic              port_ok   [NUM_PORTS];
  logic [DATA_W-1:0] gpr_q     [NUM_PHYS];

  brf_mode_decode u_mode (
    .mode_i  (mode_i),
    .bank_o  (bank),
    .legal_o (mode_legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= illegal_q | ~mode_legal;
  end

  assign illegal_mode_o = illegal_q | ~mode_legal;
  assign wr_allow       = ~illegal_mode_o;

  assign port_idx[0]       = rd_a_idx_i;
  assign port_idx[1]       = rd_b_idx_i;
  assign port_idx[PORT_WR] = wr_idx_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    brf_index_map u_map (
      .bank_i       (bank),
      .idx_i        (port_idx[p]),
      .compressed_i (compressed_i),
      .hi_access_i  (hi_access_i),
      .phys_o       (port_phys[p]),
      .ok_o         (port_ok[p])
    );
  end

  for (genvar r = 0; r < NUM_PHYS; r++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        gpr_q[r] <= '0;
      else if (wr_en_i && wr_allow && port_ok[PORT_WR] &&
               (port_phys[PORT_WR] == PHYS_W'(r)))
        gpr_q[r] <= wr_data_i;
    end
  end

  assign rd_a_data_o = port_ok[0] ? gpr_q[port_phys[0]] : '0;
  assign rd_b_data_o = port_ok[1] ? gpr_q[port_phys[1]] : '0;

  brf_saved_bank #(.DATA_W(DATA_W)) u_saved (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_i    (bank),
    .wr_en_i   (sr_wr_en_i && wr_allow),
    .wr_data_i (sr_wr_data_i),
    .rd_data_o (sr_rd_data_o)
  );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        mode_i,
  input logic              compressed_i,
  input logic              hi_access_i,
  input logic [3:0]        rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sr_wr_en_i,
  input logic [DATA_W-1:0] sr_wr_data_i,
  input logic [DATA_W-1:0] sr_rd_data_o,
  input logic              illegal_mode_o
);

  logic user_like;
  logic a_hi_blocked;
  logic mode_known;

  assign user_like    = (mode_i == MODE_USR) || (mode_i == MODE_SYS);
  assign a_hi_blocked = compressed_i && !hi_access_i &&
                        (rd_a_idx_i >= 4'd8) && (rd_a_idx_i <= 4'd12);
  assign mode_known   = (mode_i == MODE_USR) || (mode_i == MODE_FIQ) ||
                        (mode_i == MODE_IRQ) || (mode_i == MODE_SVC) ||
                        (mode_i == MODE_ABT) || (mode_i == MODE_UND) ||
                        (mode_i == MODE_SYS);

  assert_sr_user_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_like |-> (sr_rd_data_o == '0));

  assert_hi_read_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_hi_blocked |-> (rd_a_data_o == '0));

  assert_pc_shared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i == 4'd15) && !illegal_mode_o)
      |=> ((rd_a_idx_i != 4'd15) || (rd_a_data_o == $past(wr_data_i))));

  assert_illegal_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_known |-> illegal_mode_o);

  assert_illegal_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_mode_o |=> illegal_mode_o);

  assert_illegal_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_mode_o && $past(illegal_mode_o) && $stable(mode_i) &&
     $stable(rd_a_idx_i) && $stable(compressed_i) && $stable(hi_access_i))
      |-> $stable(rd_a_data_o));

  assert_illegal_no_sr_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_mode_o && $past(illegal_mode_o) && $stable(mode_i))
      |-> $stable(sr_rd_data_o));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .compressed_i   (compressed_i),
  .hi_access_i    (hi_access_i),
  .rd_a_idx_i     (rd_a_idx_i),
  .rd_a_data_o    (rd_a_data_o),
  .rd_b_idx_i     (rd_b_idx_i),
  .rd_b_data_o    (rd_b_data_o),
  .wr_en_i        (wr_en_i),
  .wr_idx_i       (wr_idx_i),
  .wr_data_i      (wr_data_i),
  .sr_wr_en_i     (sr_wr_en_i),
  .sr_wr_data_i   (sr_wr_data_i),
  .sr_rd_data_o   (sr_rd_data_o),
  .illegal_mode_o (illegal_mode_o)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
  localparam logic [4:0] M_BAD = 5'b10100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = M_USR;
  logic        comp = 1'b0;
  logic        hi = 1'b0;
  logic [3:0]  ra_idx = '0;
  logic [3:0]  rb_idx = '0;
  logic [31:0] ra_data, rb_data, sr_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wd = '0;
  logic        illegal;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  banked_regfile u_dut (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode),
    .compressed_i (comp), .hi_access_i (hi),
    .rd_a_idx_i (ra_idx), .rd_a_data_o (ra_data),
    .rd_b_idx_i (rb_idx), .rd_b_data_o (rb_data),
    .wr_en_i (wr_en), .wr_idx_i (wr_idx), .wr_data_i (wr_data),
    .sr_wr_en_i (sr_we), .sr_wr_data_i (sr_wd), .sr_rd_data_o (sr_data),
    .illegal_mode_o (illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    mode = m; wr_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sr_wr(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    mode = m; sr_wd = d; sr_we = 1'b1;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] m, input logic [3:0] idx,
                    input logic [31:0] exp);
    @(negedge clk);
    mode = m; ra_idx = idx;
    #1;
    chk(req, ra_data, exp);
  endtask

  task automatic sr_rd(input string req, input logic [4:0] m, input logic [31:0] exp);
    @(negedge clk);
    mode = m;
    #1;
    chk(req, sr_data, exp);
  endtask

  task automatic t_reset;
    rd("R1 r0", M_USR, 4'd0, 32'h0);
    rd("R1 pc", M_USR, 4'd15, 32'h0);
    rd("R1 fiq r8", M_FIQ, 4'd8, 32'h0);
    sr_rd("R1 svc saved", M_SVC, 32'h0);
    chk("R1 illegal", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_user_system;
    wr(M_USR, 4'd10, 32'hA0A0_0010);
    rd("R2 sys sees usr r10", M_SYS, 4'd10, 32'hA0A0_0010);
    wr(M_SYS, 4'd14, 32'hB0B0_0014);
    rd("R2 usr sees sys r14", M_USR, 4'd14, 32'hB0B0_0014);
  endtask

  task automatic t_fiq;
    wr(M_USR, 4'd8, 32'h1111_0008);
    wr(M_USR, 4'd13, 32'h1111_000D);
    wr(M_FIQ, 4'd8, 32'h2222_0008);
    wr(M_FIQ, 4'd13, 32'h2222_000D);
    rd("R3 usr r8 kept", M_USR, 4'd8, 32'h1111_0008);
    rd("R3 usr r13 kept", M_USR, 4'd13, 32'h1111_000D);
    rd("R3 fiq r8", M_FIQ, 4'd8, 32'h2222_0008);
    rd("R3 fiq r10 private", M_FIQ, 4'd10, 32'h0);
    wr(M_FIQ, 4'd3, 32'h3333_0003);
    rd("R3 r3 shared", M_USR, 4'd3, 32'h3333_0003);
  endtask

  task automatic t_priv;
    wr(M_IRQ, 4'd13, 32'h5100_000D);
    wr(M_SVC, 4'd13, 32'h5200_000D);
    wr(M_ABT, 4'd13, 32'h5300_000D);
    wr(M_UND, 4'd13, 32'h5400_000D);
    wr(M_SVC, 4'd14, 32'h5200_000E);
    rd("R4 irq sp", M_IRQ, 4'd13, 32'h5100_000D);
    rd("R4 svc sp", M_SVC, 4'd13, 32'h5200_000D);
    rd("R4 abt sp", M_ABT, 4'd13, 32'h5300_000D);
    rd("R4 und sp", M_UND, 4'd13, 32'h5400_000D);
    rd("R4 usr sp kept", M_USR, 4'd13, 32'h1111_000D);
    rd("R4 abt lr private", M_ABT, 4'd14, 32'h0);
    wr(M_SVC, 4'd12, 32'h5200_000C);
    rd("R4 svc r12 shared", M_USR, 4'd12, 32'h5200_000C);
    rd("R4 irq r8 shared", M_IRQ, 4'd8, 32'h1111_0008);
  endtask

  task automatic t_pc;
    wr(M_IRQ, 4'd15, 32'h0000_1C00);
    rd("R5 pc usr", M_USR, 4'd15, 32'h0000_1C00);
    rd("R5 pc fiq", M_FIQ, 4'd15, 32'h0000_1C00);
    rd("R5 pc und", M_UND, 4'd15, 32'h0000_1C00);
  endtask

  task automatic t_saved;
    sr_wr(M_FIQ, 32'h6000_0011);
    sr_wr(M_IRQ, 32'h6000_0012);
    sr_wr(M_SVC, 32'h6000_0013);
    sr_wr(M_ABT, 32'h6000_0017);
    sr_wr(M_UND, 32'h6000_001B);
    sr_rd("R6 fiq", M_FIQ, 32'h6000_0011);
    sr_rd("R6 irq", M_IRQ, 32'h6000_0012);
    sr_rd("R6 svc", M_SVC, 32'h6000_0013);
    sr_rd("R6 abt", M_ABT, 32'h6000_0017);
    sr_rd("R6 und", M_UND, 32'h6000_001B);
  endtask

  task automatic t_saved_user;
    sr_wr(M_USR, 32'hDEAD_0010);
    sr_rd("R7 usr reads zero", M_USR, 32'h0);
    sr_wr(M_SYS, 32'hDEAD_001F);
    sr_rd("R7 sys reads zero", M_SYS, 32'h0);
    sr_rd("R7 svc untouched", M_SVC, 32'h6000_0013);
    sr_rd("R7 fiq untouched", M_FIQ, 32'h6000_0011);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    mode = M_USR; ra_idx = 4'd3; rb_idx = 4'd3;
    wr_idx = 4'd3; wr_data = 32'h7777_0003; wr_en = 1'b1;
    #1;
    chk("R8 port a old", ra_data, 32'h3333_0003);
    chk("R8 port b old", rb_data, 32'h3333_0003);
    @(posedge clk);
    #1;
    chk("R8 port a new", ra_data, 32'h7777_0003);
    chk("R8 port b new", rb_data, 32'h7777_0003);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_compressed;
    @(negedge clk);
    comp = 1'b1; hi = 1'b0; rb_idx = 4'd8;
    rd("R9 r10 gated", M_USR, 4'd10, 32'h0);
    chk("R9 port b r8 gated", rb_data, 32'h0);
    wr(M_USR, 4'd10, 32'hBAD0_0010);
    rd("R9 r2 visible", M_USR, 4'd2, 32'h0);
    wr(M_USR, 4'd13, 32'h8888_000D);
    rd("R9 sp writable", M_USR, 4'd13, 32'h8888_000D);
    @(negedge clk);
    hi = 1'b1;
    rd("R9 hi form r10", M_USR, 4'd10, 32'hA0A0_0010);
    wr(M_USR, 4'd9, 32'h8888_0009);
    @(negedge clk);
    comp = 1'b0; hi = 1'b0;
    rd("R9 hi write landed", M_USR, 4'd9, 32'h8888_0009);
    rd("R9 r10 unchanged", M_USR, 4'd10, 32'hA0A0_0010);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    mode = M_BAD; wr_idx = 4'd1; wr_data = 32'hBAD0_0001; wr_en = 1'b1;
    sr_we = 1'b1; sr_wd = 32'hBAD0_5555;
    #1;
    chk("R10 flag immediate", {31'b0, illegal}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; sr_we = 1'b0;
    mode = M_USR;
    #1;
    chk("R10 flag sticky", {31'b0, illegal}, 32'h1);
    wr(M_USR, 4'd1, 32'hBAD0_0002);
    sr_wr(M_SVC, 32'hBAD0_0013);
    rd("R10 r1 not written", M_USR, 4'd1, 32'h0);
    sr_rd("R10 saved not written", M_SVC, 32'h6000_0013);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 cleared by reset", {31'b0, illegal}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 r3 zero after reset", M_USR, 4'd3, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_user_system();
    t_fiq();
    t_priv();
    t_pc();
    t_saved();
    t_saved_user();
    t_same_cycle();
    t_compressed();
    t_illegal();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule